// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The controller gathers eight interrupt request lines into one interrupt output for a host processor. Each line is synchronized, then treated as edge-triggered (a rising edge is latched as a pending request) or level-triggered (the request follows the live line), as chosen per line by a trigger-mode register. A mask register can hold any line back. Requests are then resolved by fixed priority against the set of levels currently in service. Line 0 is the highest priority and line 7 the lowest.

The host answers `intr_o` with a one-cycle acknowledge strobe. The controller replies in the next cycle with a vector byte on `data_o`, qualified by `data_oe_o`. The vector is a programmable base plus the winning level. Unless auto-EOI mode is on, the winning level is marked in service. An in-service level holds off its own level and every lower level until an end-of-interrupt command clears it. The EOI command may name a level, or it may clear the highest-priority level in service. If no request is left to resolve when the strobe arrives, the reply is the level-7 vector, and no level is marked in service.

A synchronous write port loads the vector base, the mask, the trigger modes and the commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is all ones (every line masked), every line is edge-triggered, the vector base is 0, auto-EOI is off, and nothing is in service. `intr_o` and `data_oe_o` are low.
- R2: An edge-triggered line latches a request on its rising edge. The request is cleared when the host acknowledges it. A line held high after its acknowledge raises no new request until it falls and rises again.
- R3: A level-triggered line (trigger bit 1) requests while it is high and stops requesting when it falls. If it is still high after its EOI, `intr_o` asserts again.
- R4: A masked line (mask bit 1) never asserts `intr_o`, but a latched edge request is kept while the line is masked. Unmasking a line whose request is still present asserts `intr_o`.
- R5: Among requests that are allowed, the lowest line number wins. The vector is the base plus that line number, modulo 256.
- R6: An acknowledge strobe sampled at one clock edge makes `data_oe_o` high, with the vector on `data_o`, for exactly the following cycle.
- R7: With auto-EOI off, an acknowledged level goes in service. `intr_o` then asserts only for a line of strictly higher priority than every level in service.
- R8: The specific EOI command (command register, bits 7:6 = 2'b10, level in bits 2:0) clears the in-service bit of the named level.
- R9: The non-specific EOI command (bits 7:6 = 2'b01) clears only the highest-priority level in service.
- R10: The mode command (bits 7:6 = 2'b11) sets auto-EOI from bit 0. With auto-EOI on, an acknowledge leaves no level in service, so lines of equal or lower priority interrupt again without any EOI.
- R11: An acknowledge with no allowed request returns base + 7 and marks no level in service.
- R12: Write port addresses: 0 is the vector base, 1 is the mask, 2 is the trigger modes, 3 is the command. A write takes effect at the clock edge where `wr_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, line 0 highest priority |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | One-cycle acknowledge strobe from the host |
| intr_o | output | 1 | Interrupt request to the host |
| data_o | output | 8 | Vector byte returned on acknowledge |
| data_oe_o | output | 1 | Vector byte valid |

## Verification
The bench raises two lines together, which shows whether priority is settled by the line number. It raises a higher line while a lower one is in service, which tests nesting, and a lower line under an in-service level, which must be blocked. Two levels are held in service at once, so a non-specific EOI that clears the wrong bit shows up as a premature `intr_o`. A level-mode request that is withdrawn before its acknowledge separates the spurious reply from a real level-7 reply: a fresh line-7 request must still get through. Auto-EOI is run with repeated acknowledges and no EOI in between, and the base is changed part way through the run.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_MASK = 2'd1,
    REG_TRIG = 2'd2,
    REG_CMD  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_EOI_ANY = 2'd1,
    CMD_EOI_LVL = 2'd2,
    CMD_MODE    = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/irq_req_stage.sv
module irq_req_stage #(
  parameter int unsigned N_IRQ       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] level_mode_i,
  input  logic [N_IRQ-1:0] take_i,
  output logic [N_IRQ-1:0] req_o
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_q;
    logic                   rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], irq_i[g]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // a new edge outranks a same-cycle acknowledge clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              edge_q <= 1'b0;
      else if (level_mode_i[g]) edge_q <= 1'b0;
      else if (rise)            edge_q <= 1'b1;
      else if (take_i[g])       edge_q <= 1'b0;
    end

    assign req_o[g] = level_mode_i[g] ? sync_q[SYNC_STAGES-1] : edge_q;

    AST_EDGE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i[g] && take_i[g] && !rise) |=> !edge_q); // R2
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] req_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic [N_IRQ-1:0] isr_i,
  output logic             elig_any_o,
  output logic [LVL_W-1:0] win_o,
  output logic             isr_any_o,
  output logic [LVL_W-1:0] isr_top_o
);
  logic [N_IRQ-1:0] allow;
  logic [N_IRQ-1:0] elig;

  function automatic logic [LVL_W-1:0] first_set(input logic [N_IRQ-1:0] v);
    logic [LVL_W-1:0] idx;
    idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (v[i]) idx = LVL_W'(i);
    end
    return idx;
  endfunction

  // a level in service blocks itself and everything below it
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      acc      = acc | isr_i[i];
      allow[i] = ~acc;
    end
  end

  assign elig       = req_i & ~mask_i & allow;
  assign elig_any_o = |elig;
  assign win_o      = first_set(elig);
  assign isr_any_o  = |isr_i;
  assign isr_top_o  = first_set(isr_i);
endmodule

// File: rtl/irq_service.sv
module irq_service #(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LVL_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic              aeoi_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              elig_any_i,
  input  logic [LVL_W-1:0]  win_i,
  input  logic              eoi_any_i,
  input  logic              eoi_lvl_i,
  input  logic [LVL_W-1:0]  eoi_sel_i,
  input  logic              isr_any_i,
  input  logic [LVL_W-1:0]  isr_top_i,
  output logic [N_IRQ-1:0]  isr_o,
  output logic [N_IRQ-1:0]  take_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(N_IRQ - 1);

  logic [N_IRQ-1:0]  isr_q, isr_set, isr_clr;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;
  logic [LVL_W-1:0]  vec_lvl;

  assign take_o  = (ack_i && elig_any_i) ? (N_IRQ'(1) << win_i) : '0;
  assign isr_set = aeoi_i ? '0 : take_o;

  always_comb begin
    isr_clr = '0;
    if (eoi_any_i && isr_any_i) isr_clr = isr_clr | (N_IRQ'(1) << isr_top_i);
    if (eoi_lvl_i)              isr_clr = isr_clr | (N_IRQ'(1) << eoi_sel_i);
  end

  assign vec_lvl = elig_any_i ? win_i : SPUR_LVL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      oe_q  <= ack_i;
      if (ack_i) data_q <= base_i + {{(DATA_W-LVL_W){1'b0}}, vec_lvl};
    end
  end

  assign isr_o     = isr_q;
  assign data_o    = data_q;
  assign data_oe_o = oe_q;

  AST_ACK_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> data_oe_o); // R6
  AST_NO_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !data_oe_o); // R6
  AST_SPUR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !elig_any_i) |=> data_o == $past(base_i) + DATA_W'(N_IRQ - 1)); // R11
  AST_SPUR_NO_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !elig_any_i && !eoi_any_i && !eoi_lvl_i) |=> isr_q == $past(isr_q)); // R11
  AST_AEOI_NO_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi_i && !eoi_any_i && !eoi_lvl_i) |=> isr_q == $past(isr_q)); // R10
  AST_ISR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && elig_any_i && !aeoi_i) |=> isr_q[$past(win_i)]); // R7
  AST_EOI_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_lvl_i && !ack_i) |=> !isr_q[$past(eoi_sel_i)]); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_IRQ       = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LVL_W      = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic              intr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [DATA_W-1:0] base_q;
  logic [N_IRQ-1:0]  mask_q, trig_q;
  logic              aeoi_q;

  logic              cmd_wr;
  cmd_op_e           cmd_op;
  logic              eoi_any, eoi_lvl;
  logic [LVL_W-1:0]  eoi_sel;

  logic [N_IRQ-1:0]  req, isr, take;
  logic              elig_any, isr_any;
  logic [LVL_W-1:0]  win, isr_top;

  assign cmd_wr  = wr_en_i && (wr_addr_i == REG_CMD);
  assign cmd_op  = cmd_op_e'(wr_data_i[DATA_W-1 -: 2]);
  assign eoi_any = cmd_wr && (cmd_op == CMD_EOI_ANY);
  assign eoi_lvl = cmd_wr && (cmd_op == CMD_EOI_LVL);
  assign eoi_sel = wr_data_i[LVL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '1;
      trig_q <= '0;
      aeoi_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_BASE: base_q <= wr_data_i;
        REG_MASK: mask_q <= wr_data_i[N_IRQ-1:0];
        REG_TRIG: trig_q <= wr_data_i[N_IRQ-1:0];
        default:  if (cmd_op == CMD_MODE) aeoi_q <= wr_data_i[0];
      endcase
    end
  end

  irq_req_stage #(.N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .level_mode_i(trig_q),
    .take_i      (take),
    .req_o       (req)
  );

  irq_prio_resolve #(.N_IRQ(N_IRQ)) u_res (
    .req_i     (req),
    .mask_i    (mask_q),
    .isr_i     (isr),
    .elig_any_o(elig_any),
    .win_o     (win),
    .isr_any_o (isr_any),
    .isr_top_o (isr_top)
  );

  irq_service #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_i),
    .aeoi_i    (aeoi_q),
    .base_i    (base_q),
    .elig_any_i(elig_any),
    .win_i     (win),
    .eoi_any_i (eoi_any),
    .eoi_lvl_i (eoi_lvl),
    .eoi_sel_i (eoi_sel),
    .isr_any_i (isr_any),
    .isr_top_i (isr_top),
    .isr_o     (isr),
    .take_o    (take),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assign intr_o = elig_any;

  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !intr_o); // R4
  AST_EOI_ANY_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_any && isr_any && !ack_i) |=> !isr[$past(isr_top)]); // R9
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       intr;
  logic [7:0] data;
  logic       data_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_tag_q[$];

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
    .intr_o(intr), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // driver: push the expected vector, then strobe acknowledge
  task automatic do_ack(input logic [7:0] exp);
    exp_q.push_back(exp);
    ack = 1'b1;
    @(posedge clk); #1;
    ack = 1'b0;
    tick(1);
  endtask

  task automatic chk_intr(input logic exp, input string req);
    tick(6);
    check(intr === exp, req, int'(intr), int'(exp));
  endtask

  // monitor: compare each reply with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && data_oe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected reply", int'(data), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(data === e, "R5 R6 R11 vector", int'(data), int'(e));
      end
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    check(intr === 1'b0, "R1 intr in reset", int'(intr), 0);
    check(data_oe === 1'b0, "R1 oe in reset", int'(data_oe), 0);
    rst_n = 1'b1;
    tick(1);
    irq[3] = 1'b1;
    chk_intr(1'b0, "R1 R4 masked after reset");

    // R12 base and mask writes; latched edge while masked
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00);
    chk_intr(1'b1, "R4 unmask with pending edge");
    do_ack(8'h23);
    chk_intr(1'b0, "R2 edge consumed by ack");
    wr(2'd3, 8'h40);
    chk_intr(1'b0, "R2 held line no new request");
    irq[3] = 1'b0;
    tick(4);

    // R5 priority and R7 blocking / nesting, R9, R8
    irq[5] = 1'b1; irq[2] = 1'b1;
    chk_intr(1'b1, "R5 two requests");
    do_ack(8'h22);
    chk_intr(1'b0, "R7 lower blocked by in-service");
    wr(2'd3, 8'h40);
    chk_intr(1'b1, "R9 eoi releases lower");
    do_ack(8'h25);
    irq[1] = 1'b1;
    chk_intr(1'b1, "R7 higher nests");
    do_ack(8'h21);
    chk_intr(1'b0, "R7 all consumed");
    wr(2'd3, 8'h40);
    irq[6] = 1'b1;
    chk_intr(1'b0, "R9 only top level cleared");
    wr(2'd3, 8'h85);
    chk_intr(1'b1, "R8 specific eoi level 5");
    do_ack(8'h26);
    wr(2'd3, 8'h86);
    irq[1] = 1'b0; irq[2] = 1'b0; irq[5] = 1'b0; irq[6] = 1'b0;
    chk_intr(1'b0, "R8 idle after eoi");

    // R3 level mode on line 4
    wr(2'd2, 8'h10);
    irq[4] = 1'b1;
    chk_intr(1'b1, "R3 level request");
    irq[4] = 1'b0;
    chk_intr(1'b0, "R3 level withdrawn");
    irq[4] = 1'b1;
    chk_intr(1'b1, "R3 level again");
    do_ack(8'h24);
    chk_intr(1'b0, "R7 level in service");
    wr(2'd3, 8'h40);
    chk_intr(1'b1, "R3 still high after eoi");
    irq[4] = 1'b0;
    chk_intr(1'b0, "R3 dropped");

    // R11 spurious reply, then a real level-7 request must pass
    irq[4] = 1'b1;
    chk_intr(1'b1, "R11 setup");
    irq[4] = 1'b0;
    tick(5);
    do_ack(8'h27);
    irq[7] = 1'b1;
    chk_intr(1'b1, "R11 no in-service after spurious");
    do_ack(8'h27);
    wr(2'd3, 8'h87);
    irq[7] = 1'b0;
    chk_intr(1'b0, "R11 idle");

    // R4 mask single line
    wr(2'd1, 8'h01);
    irq[0] = 1'b1;
    chk_intr(1'b0, "R4 masked line");
    wr(2'd1, 8'h00);
    chk_intr(1'b1, "R4 unmask");
    do_ack(8'h20);
    wr(2'd3, 8'h40);
    irq[0] = 1'b0;
    tick(4);

    // R10 auto-EOI with a new base
    wr(2'd3, 8'hC1);
    wr(2'd0, 8'h70);
    irq[3] = 1'b1; irq[6] = 1'b1;
    chk_intr(1'b1, "R10 setup");
    do_ack(8'h73);
    chk_intr(1'b1, "R10 lower not blocked");
    do_ack(8'h76);
    chk_intr(1'b0, "R10 consumed");
    irq[3] = 1'b0;
    tick(4);
    irq[3] = 1'b1;
    chk_intr(1'b1, "R10 same level again without eoi");
    do_ack(8'h73);

    tick(3);
    check(exp_q.size() == 0, "R6 all replies seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule